// File: doc/BRIEF.md
# SPI-Attached BCD Calendar Clock

This block is an SPI target that holds sixteen 8-bit registers of a calendar clock and keeps the time running. Seconds, minutes, hours, weekday, day, month and year are kept in BCD. An external one-cycle pulse marks each elapsed second and advances the time with full carry up to the year. A host reads or writes the registers through frames framed by an active-high chip select. The first byte of a frame is a command that names a register and a transfer type. The bytes after it carry data.

All SPI inputs are sampled on the system clock through synchronizer stages, so `spi_sck` must be much slower than `clk`. A whole time set or time read is meant to be done as one burst over registers 0 to 6. Ticks that arrive while a frame is open are held back and applied after chip select drops. This keeps all seven values from one instant. The hour register can count in 24-hour form or in 12-hour form with a PM flag, depending on a control bit.

Top module: `spi_rtc_regfile`

## Requirements
- R1: The command byte carries the register number in bits [7:4]. Bit 3 set means single, clear means burst. Bit 2 set means read, clear means write. Bits [1:0] are ignored. So 0x8 is a single write, 0xC a single read, 0x0 a burst write and 0x4 a burst read.
- R2: Chip select is active high and data goes MSB first in SPI mode 1. The target drives `spi_miso` after a rising `spi_sck` edge and samples `spi_mosi` on the falling edge. `spi_miso` is 0 during command and write bytes and while chip select is low.
- R3: A burst moves to the next register after every data byte, and register 15 is followed by register 0.
- R4: A single transfer moves only the first data byte. Later write bytes in the same frame are dropped, and later read bytes return 0x00.
- R5: Register 13 always reads 0x00, and writes to it are dropped.
- R6: After reset the map is as follows. Control-1 (register 14) is 0x20, which selects 24-hour mode. Control-2 (register 15) is 0x10, the oscillator-stopped flag. Day (4) and month (5) are 0x01. Hour (2) is 0x00. Every other register is 0x00.
- R7: While bit 4 of control-2 is 1, second ticks change nothing. Writing 0x00 to control-2 lets the clock run.
- R8: Seconds (register 0) and minutes (register 1) count 00 to 59 in BCD. A nibble 9 carries into the tens digit, and 59 rolls to 00 with a carry into the next field.
- R9: With control-1 bit 5 set, the hour counts 00 to 23 in BCD, and 23 rolls to 00 with a carry into the day.
- R10: With control-1 bit 5 clear, hour bits [4:0] hold BCD 01 to 12 and bit 5 marks PM. 11 steps to 12 and flips PM, 12 steps to 01, and only 11 PM to 12 AM carries into the day.
- R11: The day (register 4) rolls to 01 after the last day of its month. February has 29 days when the BCD year is divisible by 4 and 28 otherwise. On each day carry the weekday (register 3) counts 0 to 6 and wraps, and the month (register 5, bits [4:0]) rolls 12 to 01 with a carry into the year.
- R12: The year (register 6) rolls 99 to 00 and then flips bit 7 of the month register, the century flag.
- R13: The time registers do not change through a tick while chip select is high. A tick seen during a frame is applied once after chip select is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all SPI inputs are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | SPI clock from the host, idle low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |

## Verification
The carry chain is driven from preset times, each chosen so that the carry stops at a different field. The cases are a tens-digit step in the minutes, a 23:59:59 rollover into a 28-day February, the leap-year February, a 30-day month, and a New Year with a year wrap. Together they show which field length or leap rule is wrong. The 12-hour cases cover 11 AM, 12 PM, 11 PM and 12 AM, which separates the PM flip from the day carry. On the SPI side, single and burst commands, a burst that runs over register 15, extra bytes after a single transfer, and a tick raised in the middle of an open read frame each isolate one part of the decoder or of the deferral.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam logic [3:0] RA_SEC  = 4'd0;
   localparam logic [3:0] RA_MIN  = 4'd1;
   localparam logic [3:0] RA_HOUR = 4'd2;
   localparam logic [3:0] RA_WDAY = 4'd3;
   localparam logic [3:0] RA_DAY  = 4'd4;
   localparam logic [3:0] RA_MON  = 4'd5;
   localparam logic [3:0] RA_YEAR = 4'd6;
   localparam logic [3:0] RA_HOLE = 4'd13;
   localparam logic [3:0] RA_CFG  = 4'd14;
   localparam logic [3:0] RA_OSC  = 4'd15;
   localparam int FMT24_BIT = 5;
   localparam int PM_BIT    = 5;
   localparam int CENT_BIT  = 7;
   localparam int HALT_BIT  = 4;

   // add one to a two-digit BCD value (no range check)
   function automatic logic [7:0] bcd_up(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // last day of a month, in BCD
   function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
      logic [7:0] ybin;
      ybin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
      case (mon[4:0])
         5'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_spi_shifter.sv
module rtc_spi_shifter #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_i,
   input  logic       cs_i,
   input  logic       mosi_i,
   input  logic       tx_load,
   input  logic [7:0] tx_byte,
   output logic       miso_o,
   output logic       frame_active,
   output logic       byte_done,
   output logic [7:0] rx_byte
);
   localparam int TOP = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be 2 or more");
      end
   endgenerate

   logic [TOP:0] sck_sr, cs_sr, mosi_sr;
   logic         sck_d;
   logic [2:0]   bit_cnt;
   logic [7:0]   tx_sh, rx_sh;
   logic         sck_rise, sck_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_sr  <= '0;
         cs_sr   <= '0;
         mosi_sr <= '0;
      end else begin
         sck_sr  <= {sck_sr[TOP-1:0], sck_i};
         cs_sr   <= {cs_sr[TOP-1:0], cs_i};
         mosi_sr <= {mosi_sr[TOP-1:0], mosi_i};
      end
   end

   assign frame_active = cs_sr[TOP];
   assign sck_rise     = sck_sr[TOP] & ~sck_d;
   assign sck_fall     = ~sck_sr[TOP] & sck_d;
   assign rx_byte      = rx_sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_d     <= 1'b0;
         bit_cnt   <= '0;
         tx_sh     <= '0;
         rx_sh     <= '0;
         miso_o    <= 1'b0;
         byte_done <= 1'b0;
      end else begin
         sck_d     <= sck_sr[TOP];
         byte_done <= 1'b0;
         if (!frame_active) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
            miso_o  <= 1'b0;
         end else begin
            if (tx_load) begin
               tx_sh <= tx_byte;
            end else if (sck_rise) begin
               miso_o <= tx_sh[7];
               tx_sh  <= {tx_sh[6:0], 1'b0};
            end
            if (sck_fall) begin
               rx_sh   <= {rx_sh[6:0], mosi_sr[TOP]};
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) byte_done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rtc_cmd_ctrl.sv
module rtc_cmd_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_active,
   input  logic       byte_done,
   input  logic [7:0] rx_byte,
   input  logic [7:0] rd_data,
   output logic [3:0] rd_addr,
   output logic       wr_en,
   output logic [3:0] wr_addr,
   output logic [7:0] wr_data,
   output logic       tx_load,
   output logic [7:0] tx_byte
);
   logic       have_cmd, is_read, is_single, spent, load_req;
   logic [3:0] addr;

   assign rd_addr = addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_cmd  <= 1'b0;
         is_read   <= 1'b0;
         is_single <= 1'b0;
         spent     <= 1'b0;
         load_req  <= 1'b0;
         addr      <= '0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         tx_load   <= 1'b0;
         tx_byte   <= '0;
      end else begin
         wr_en    <= 1'b0;
         tx_load  <= 1'b0;
         load_req <= 1'b0;
         if (!frame_active) begin
            have_cmd <= 1'b0;
            spent    <= 1'b0;
         end else if (load_req) begin
            tx_load <= 1'b1;
            tx_byte <= spent ? 8'h00 : rd_data;
            if (!spent) begin
               if (is_single) spent <= 1'b1;
               else           addr  <= addr + 4'd1;
            end
         end else if (byte_done) begin
            if (!have_cmd) begin
               have_cmd  <= 1'b1;
               addr      <= rx_byte[7:4];
               is_single <= rx_byte[3];
               is_read   <= rx_byte[2];
               load_req  <= rx_byte[2];
            end else if (is_read) begin
               load_req <= 1'b1;
            end else if (!spent) begin
               wr_en   <= 1'b1;
               wr_addr <= addr;
               wr_data <= rx_byte;
               if (is_single) spent <= 1'b1;
               else           addr  <= addr + 4'd1;
            end
         end
      end
   end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
   import rtc_pkg::*;
#(
   parameter bit DEF_24H = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_active,
   input  logic       tick,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [3:0] rd_addr,
   output logic [7:0] rd_data,
   output logic [7:0] sec_o,
   output logic       halt_o,
   output logic       adv_o
);
   localparam int         NREG     = 16;
   localparam logic [7:0] HOUR_RST = DEF_24H ? 8'h00 : 8'h12;
   localparam logic [7:0] CFG_RST  = DEF_24H ? 8'h20 : 8'h00;

   function automatic logic [7:0] reset_val(input int idx);
      case (idx)
         4, 5:    return 8'h01;
         2:       return HOUR_RST;
         14:      return CFG_RST;
         15:      return 8'h10;
         default: return 8'h00;
      endcase
   endfunction

   logic [7:0] rf [NREG];
   logic       pend;
   logic [7:0] n_sec, n_min, n_hr, n_wd, n_day, n_mon, n_yr, hn, mon_lo;
   logic       c_sec, c_min, hc, c_hr, c_day, c_mon, c_yr;

   assign halt_o  = rf[RA_OSC][HALT_BIT];
   assign sec_o   = rf[RA_SEC];
   assign adv_o   = !frame_active && !halt_o && (tick || pend);
   assign rd_data = (rd_addr == RA_HOLE) ? 8'h00 : rf[rd_addr];

   always_comb begin
      c_sec = rf[RA_SEC] == 8'h59;
      n_sec = c_sec ? 8'h00 : bcd_up(rf[RA_SEC]);
      c_min = c_sec && rf[RA_MIN] == 8'h59;
      n_min = c_sec ? ((rf[RA_MIN] == 8'h59) ? 8'h00 : bcd_up(rf[RA_MIN])) : rf[RA_MIN];
      if (rf[RA_CFG][FMT24_BIT]) begin
         hc = rf[RA_HOUR] == 8'h23;
         hn = hc ? 8'h00 : bcd_up(rf[RA_HOUR]);
      end else if (rf[RA_HOUR][4:0] == 5'h12) begin
         hc = 1'b0;
         hn = {2'b00, rf[RA_HOUR][PM_BIT], 5'h01};
      end else if (rf[RA_HOUR][4:0] == 5'h11) begin
         hc = rf[RA_HOUR][PM_BIT];
         hn = {2'b00, ~rf[RA_HOUR][PM_BIT], 5'h12};
      end else begin
         hc = 1'b0;
         hn = bcd_up({3'b000, rf[RA_HOUR][4:0]});
         hn = {2'b00, rf[RA_HOUR][PM_BIT], hn[4:0]};
      end
      n_hr  = c_min ? hn : rf[RA_HOUR];
      c_hr  = c_min && hc;
      c_day = c_hr && (rf[RA_DAY] == month_last(rf[RA_MON], rf[RA_YEAR]));
      n_day = c_hr ? (c_day ? 8'h01 : bcd_up(rf[RA_DAY])) : rf[RA_DAY];
      n_wd  = c_hr ? ((rf[RA_WDAY] >= 8'd6) ? 8'h00 : rf[RA_WDAY] + 8'd1) : rf[RA_WDAY];
      c_mon = c_day && rf[RA_MON][4:0] == 5'h12;
      c_yr  = c_mon && rf[RA_YEAR] == 8'h99;
      n_yr  = c_mon ? (c_yr ? 8'h00 : bcd_up(rf[RA_YEAR])) : rf[RA_YEAR];
      mon_lo = bcd_up({3'b000, rf[RA_MON][4:0]});
      n_mon = c_day ? {rf[RA_MON][CENT_BIT] ^ c_yr, 2'b00, c_mon ? 5'h01 : mon_lo[4:0]}
                    : rf[RA_MON];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         for (int i = 0; i < NREG; i++) rf[i] <= reset_val(i);
      end else begin
         if (frame_active) begin
            if (tick && !halt_o) pend <= 1'b1;
         end else begin
            pend <= 1'b0;
         end
         if (adv_o) begin
            rf[RA_SEC]  <= n_sec;
            rf[RA_MIN]  <= n_min;
            rf[RA_HOUR] <= n_hr;
            rf[RA_WDAY] <= n_wd;
            rf[RA_DAY]  <= n_day;
            rf[RA_MON]  <= n_mon;
            rf[RA_YEAR] <= n_yr;
         end
         if (wr_en && wr_addr != RA_HOLE) rf[wr_addr] <= wr_data;
      end
   end
endmodule

// File: rtl/spi_rtc_regfile.sv
module spi_rtc_regfile #(
   parameter int SYNC_STAGES = 2,
   parameter bit DEF_24H     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs,
   input  logic spi_mosi,
   output logic spi_miso,
   input  logic sec_tick
);
   logic       fa_w, bdone_w, wr_en_w, tx_load_w, halt_w, adv_w;
   logic [7:0] rx_w, rd_data_w, wr_data_w, tx_byte_w, sec_w;
   logic [3:0] rd_addr_w, wr_addr_w;

   rtc_spi_shifter #(.SYNC_STAGES(SYNC_STAGES)) shift_i (
      .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_i(spi_cs), .mosi_i(spi_mosi),
      .tx_load(tx_load_w), .tx_byte(tx_byte_w), .miso_o(spi_miso),
      .frame_active(fa_w), .byte_done(bdone_w), .rx_byte(rx_w)
   );

   rtc_cmd_ctrl ctrl_i (
      .clk(clk), .rst_n(rst_n), .frame_active(fa_w), .byte_done(bdone_w),
      .rx_byte(rx_w), .rd_data(rd_data_w), .rd_addr(rd_addr_w),
      .wr_en(wr_en_w), .wr_addr(wr_addr_w), .wr_data(wr_data_w),
      .tx_load(tx_load_w), .tx_byte(tx_byte_w)
   );

   rtc_time_core #(.DEF_24H(DEF_24H)) core_i (
      .clk(clk), .rst_n(rst_n), .frame_active(fa_w), .tick(sec_tick),
      .wr_en(wr_en_w), .wr_addr(wr_addr_w), .wr_data(wr_data_w),
      .rd_addr(rd_addr_w), .rd_data(rd_data_w), .sec_o(sec_w),
      .halt_o(halt_w), .adv_o(adv_w)
   );
endmodule

// File: rtl/rtc_spi_chk.sv
module rtc_spi_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs,
   input logic       miso,
   input logic       frame_active,
   input logic       wr_en,
   input logic       tx_load,
   input logic [7:0] sec,
   input logic       halt,
   input logic       adv
);
   AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs && !$past(cs) && !$past(cs, 2) && !$past(cs, 3)) |-> !miso);   // R2
   AST_FROZEN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_active && !wr_en) |=> $stable(sec));                         // R13
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !wr_en) |=> $stable(sec));                                 // R7
   AST_LOAD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> frame_active);                                          // R1
   AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);                                                  // R4
   AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !wr_en && sec[3:0] < 4'd9) |=> (sec == $past(sec) + 8'd1)); // R8
endmodule

bind spi_rtc_regfile rtc_spi_chk chk_i (
   .clk(clk), .rst_n(rst_n), .cs(spi_cs), .miso(spi_miso),
   .frame_active(fa_w), .wr_en(wr_en_w), .tx_load(tx_load_w),
   .sec(sec_w), .halt(halt_w), .adv(adv_w)
);

// File: tb/spi_rtc_regfile_tb_top.sv
module spi_rtc_regfile_tb_top;
   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs = 1'b0, mosi = 1'b0, tick = 1'b0;
   logic miso;
   int   checks = 0, errors = 0;
   localparam int HALF = 10;
   logic [7:0] wbuf [16];
   logic [7:0] rbuf [16];

   always #4 clk = ~clk;

   spi_rtc_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs(cs),
      .spi_mosi(mosi), .spi_miso(miso), .sec_tick(tick)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         sck = 1'b1; mosi = tx[i];
         wait_clk(HALF);
         rx[i] = miso;
         sck = 1'b0;
         wait_clk(HALF);
      end
   endtask

   task automatic cs_on();  cs = 1'b1; wait_clk(HALF); endtask
   task automatic cs_off(); wait_clk(HALF); cs = 1'b0; wait_clk(HALF); endtask

   task automatic burst_write(input logic [3:0] a, input int n);
      logic [7:0] r;
      cs_on();
      xfer({a, 4'h0}, r);
      chk("R2 miso quiet in command", r, 8'h00);
      for (int i = 0; i < n; i++) begin
         xfer(wbuf[i], r);
         chk("R2 miso quiet in write", r, 8'h00);
      end
      cs_off();
   endtask

   task automatic burst_read(input logic [3:0] a, input int n);
      logic [7:0] r;
      cs_on();
      xfer({a, 4'h4}, r);
      for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
      cs_off();
   endtask

   task automatic single_write(input logic [3:0] a, input logic [7:0] d);
      logic [7:0] r;
      cs_on(); xfer({a, 4'h8}, r); xfer(d, r); cs_off();
   endtask

   task automatic single_read(input logic [3:0] a, output logic [7:0] d);
      logic [7:0] r;
      cs_on(); xfer({a, 4'hC}, r); xfer(8'h00, d); cs_off();
   endtask

   task automatic pulse_tick();
      tick = 1'b1; wait_clk(1); tick = 1'b0; wait_clk(3);
   endtask

   task automatic set_time(input logic [7:0] s, mi, h, wd, d, mo, y);
      wbuf[0] = s; wbuf[1] = mi; wbuf[2] = h; wbuf[3] = wd;
      wbuf[4] = d; wbuf[5] = mo; wbuf[6] = y;
      burst_write(4'd0, 7);
   endtask

   task automatic expect_time(input string req, input logic [7:0] s, mi, h, wd, d, mo, y);
      burst_read(4'd0, 7);
      chk({req, " sec"}, rbuf[0], s);
      chk({req, " min"}, rbuf[1], mi);
      chk({req, " hour"}, rbuf[2], h);
      chk({req, " weekday"}, rbuf[3], wd);
      chk({req, " day"}, rbuf[4], d);
      chk({req, " month"}, rbuf[5], mo);
      chk({req, " year"}, rbuf[6], y);
   endtask

   task automatic t_reset();
      burst_read(4'd0, 16);
      for (int i = 0; i < 16; i++) begin
         logic [7:0] e;
         e = (i == 4 || i == 5) ? 8'h01 : (i == 14) ? 8'h20 : (i == 15) ? 8'h10 : 8'h00;
         chk("R6 reset map", rbuf[i], e);
      end
   endtask

   task automatic t_halt();
      logic [7:0] d;
      pulse_tick();
      single_read(4'd0, d);
      chk("R7 tick ignored while halted", d, 8'h00);
      single_write(4'd15, 8'h00);
      pulse_tick();
      single_read(4'd0, d);
      chk("R7 clock runs after clear", d, 8'h01);
   endtask

   task automatic t_wrap();
      logic [7:0] d;
      wbuf[0] = 8'h20; wbuf[1] = 8'h00; wbuf[2] = 8'h45;
      burst_write(4'd14, 3);
      single_read(4'd0, d);
      chk("R3 burst write wrapped to reg 0", d, 8'h45);
      burst_read(4'd15, 2);
      chk("R3 burst read reg 15", rbuf[0], 8'h00);
      chk("R3 burst read wrapped to reg 0", rbuf[1], 8'h45);
   endtask

   task automatic t_single();
      logic [7:0] r;
      cs_on(); xfer(8'h88, r); xfer(8'h11, r); xfer(8'h22, r); cs_off();
      burst_read(4'd8, 2);
      chk("R4 single write first byte", rbuf[0], 8'h11);
      chk("R4 extra write byte dropped", rbuf[1], 8'h00);
      cs_on(); xfer(8'h8C, r); xfer(8'h00, r);
      chk("R4 single read data", r, 8'h11);
      xfer(8'h00, r);
      chk("R4 extra read byte zero", r, 8'h00);
      cs_off();
      single_write(4'd1, 8'h37);
      cs_on(); xfer(8'h1F, r); xfer(8'h00, r); cs_off();
      chk("R1 low command bits ignored", r, 8'h37);
   endtask

   task automatic t_hole();
      logic [7:0] d;
      single_write(4'd13, 8'hFF);
      single_read(4'd13, d);
      chk("R5 reg 13 reads zero", d, 8'h00);
   endtask

   task automatic t_roll24();
      set_time(8'h59, 8'h09, 8'h07, 8'h02, 8'h15, 8'h06, 8'h23);
      pulse_tick();
      expect_time("R8 minute digit carry", 8'h00, 8'h10, 8'h07, 8'h02, 8'h15, 8'h06, 8'h23);
      set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h28, 8'h02, 8'h23);
      pulse_tick();
      expect_time("R9 R11 february non leap", 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23);
      set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
      pulse_tick();
      expect_time("R11 leap february", 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24);
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h24);
      pulse_tick();
      expect_time("R11 thirty day month", 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h05, 8'h24);
   endtask

   task automatic t_year();
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
      pulse_tick();
      expect_time("R12 century flag", 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h81, 8'h00);
   endtask

   task automatic t_12h();
      single_write(4'd14, 8'h00);
      set_time(8'h59, 8'h59, 8'h11, 8'h00, 8'h10, 8'h01, 8'h25);
      pulse_tick();
      expect_time("R10 11AM to 12PM", 8'h00, 8'h00, 8'h32, 8'h00, 8'h10, 8'h01, 8'h25);
      set_time(8'h59, 8'h59, 8'h32, 8'h00, 8'h10, 8'h01, 8'h25);
      pulse_tick();
      expect_time("R10 12PM to 1PM", 8'h00, 8'h00, 8'h21, 8'h00, 8'h10, 8'h01, 8'h25);
      set_time(8'h59, 8'h59, 8'h31, 8'h00, 8'h10, 8'h01, 8'h25);
      pulse_tick();
      expect_time("R10 11PM to 12AM", 8'h00, 8'h00, 8'h12, 8'h01, 8'h11, 8'h01, 8'h25);
      set_time(8'h59, 8'h59, 8'h12, 8'h00, 8'h10, 8'h01, 8'h25);
      pulse_tick();
      expect_time("R10 12AM to 1AM", 8'h00, 8'h00, 8'h01, 8'h00, 8'h10, 8'h01, 8'h25);
      single_write(4'd14, 8'h20);
   endtask

   task automatic t_defer();
      logic [7:0] r;
      single_write(4'd0, 8'h10);
      cs_on();
      xfer(8'h04, r);
      pulse_tick();
      xfer(8'h00, r);
      chk("R13 frame value unchanged", r, 8'h10);
      wait_clk(HALF);
      cs = 1'b0;
      wait_clk(2 * HALF);
      single_read(4'd0, r);
      chk("R13 held tick applied", r, 8'h11);
   endtask

   initial begin
      #(8 * 190000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_halt();
      t_wrap();
      t_single();
      t_hole();
      t_roll24();
      t_year();
      t_12h();
      t_defer();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule